// File: doc/BRIEF.md
# Shared-Estimator Probabilistic Flow Counter

This block keeps approximate packet counts for many flows in very little storage. Each flow holds only a short index into one shared, software-loaded table. That table lists estimate values in non-decreasing order, with the first entry pinned at zero. When a packet event arrives for a flow, the block reads the flow's index and draws a 16-bit pseudo-random number. The number is compared against a stored increment probability for that index, which is the reciprocal of the gap to the next estimate, precomputed and scaled to 2^16. If the draw succeeds, the index moves up by one. The estimate the index selects is an unbiased guess of the true count.

The table is filled through a write port, one entry per cycle. Each entry holds an unsigned fixed-point estimate and its advance probability. Packet events arrive as a valid/flow-id pair, one per cycle, and may target the same flow on consecutive cycles. A separate query port returns a flow's current estimate one cycle after the flow is named.

Top module: `flow_est_counter`

## Requirements
- R1: After reset every flow index is 0, every table entry (estimate and probability) is 0, and `rd_estimate` is 0.
- R2: A cycle with `tbl_we` high stores `tbl_est` and `tbl_prob` at entry `tbl_idx`. A query issued in any later cycle sees the new estimate.
- R3: Each packet event changes its flow's index by 0 or +1, never more.
- R4: An index equal to NUM_EST-1 saturates: further events leave it unchanged, whatever its probability.
- R5: An event advances the index i only when the current 16-bit LFSR value (range 1..65535) is strictly below the 17-bit probability of entry i. A probability of 65536 always advances; a probability of 0 never does.
- R6: Events for the same flow on consecutive cycles each act on the index left by the previous one. N back-to-back events with probability 65536 advance the index by N, up to saturation.
- R7: `rd_estimate` in the cycle after `rd_flow_id` is presented equals the table estimate at that flow's index. The index includes every event presented two or more cycles before the query cycle.
- R8: Entry 0's estimate always reads 0. A write to entry 0 stores only its probability and ignores `tbl_est`.
- R9: Events for one flow never change the index of any other flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Packet event present this cycle |
| flow_id | input | FLOW_W | Flow the packet event belongs to |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Table entry being written |
| tbl_est | input | EST_W | Unsigned fixed-point estimate for the entry |
| tbl_prob | input | PROB_W+1 | Advance probability, scaled so 2^PROB_W means certain |
| rd_flow_id | input | FLOW_W | Flow whose estimate is queried |
| rd_estimate | output | EST_W | Estimate of the queried flow, one cycle later |

## Verification
Two functions can meet in the same cycle on the same flow. One is the write-back of an index update. The other is the index read for a following event, or a query. The bench provokes the read-after-write case by issuing bursts of events to one flow with no idle gap, in directed runs and in random streams with zero-length gaps. The table probabilities are 0 or 65536, so the outcome is deterministic. A bench model then predicts the exact index each flow reaches. Every queried estimate is judged against the table value at that predicted index, which also covers saturation, blocked entries and untouched neighbour flows.

// File: rtl/est_pkg.sv
// Package: constants and the pseudo-random step shared by the counter.
// Assumes a 16-bit maximal-length Galois LFSR is enough for draws.
package est_pkg;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_POLY = 16'hB400;

    // Next state of the Galois shift register (never reaches zero from nonzero).
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] cur);
        logic [LFSR_W-1:0] nxt;
        nxt = cur >> 1;
        if (cur[0]) nxt = nxt ^ LFSR_POLY;
        return nxt;
    endfunction
endpackage

// File: rtl/est_lfsr.sv
// Module: free-running pseudo-random source for increment decisions.
// Assumes SEED is nonzero; the value then stays in 1..2^16-1.
module est_lfsr
    import est_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] value
);
    // Step the register once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= SEED;
        else        value <= lfsr_step(value);
    end
endmodule

// File: rtl/est_table.sv
// Module: shared table of estimates and per-entry advance probabilities.
// Assumes software loads entries in non-decreasing estimate order; entry 0
// estimate is hard-wired to zero. Two combinational lookups.
module est_table #(
    parameter int NUM_EST = 16,
    parameter int EST_W   = 32,
    parameter int PROB_W  = 16,
    localparam int IDX_W  = $clog2(NUM_EST)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [EST_W-1:0] wr_est,
    input  logic [PROB_W:0]  wr_prob,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [PROB_W:0]  lk_prob,
    input  logic [IDX_W-1:0] q_idx,
    output logic [EST_W-1:0] q_est
);
    logic [EST_W-1:0] est_q  [NUM_EST];
    logic [PROB_W:0]  prob_q [NUM_EST];

    for (genvar g = 0; g < NUM_EST; g++) begin : g_entry
        // Probability storage for entry g.
        always_ff @(posedge clk) begin
            if (!rst_n)                           prob_q[g] <= '0;
            else if (we && wr_idx == IDX_W'(g))   prob_q[g] <= wr_prob;
        end
        if (g == 0) begin : g_zero
            // Entry 0 estimate is constant zero.
            always_comb est_q[g] = '0;
        end else begin : g_val
            // Estimate storage for entry g.
            always_ff @(posedge clk) begin
                if (!rst_n)                           est_q[g] <= '0;
                else if (we && wr_idx == IDX_W'(g))   est_q[g] <= wr_est;
            end
        end
    end

    // Lookups for the update stage and the query port.
    always_comb begin
        lk_prob = prob_q[lk_idx];
        q_est   = est_q[q_idx];
    end
endmodule

// File: rtl/flow_ptr_ram.sv
// Module: per-flow index storage, one write port and two read ports.
// Assumes at most one write per cycle; reads see the pre-edge contents.
module flow_ptr_ram #(
    parameter int NUM_FLOWS = 64,
    parameter int IDX_W     = 4,
    localparam int FLOW_W   = $clog2(NUM_FLOWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [FLOW_W-1:0] wr_flow,
    input  logic [IDX_W-1:0]  wr_ptr,
    input  logic [FLOW_W-1:0] ev_flow,
    output logic [IDX_W-1:0]  ev_ptr,
    input  logic [FLOW_W-1:0] q_flow,
    output logic [IDX_W-1:0]  q_ptr
);
    logic [IDX_W-1:0] ptr_q [NUM_FLOWS];

    // Clear all indices on reset, else write back one updated index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < NUM_FLOWS; f++) ptr_q[f] <= '0;
        end else if (we) begin
            ptr_q[wr_flow] <= wr_ptr;
        end
    end

    // Combinational reads for the event path and the query path.
    always_comb begin
        ev_ptr = ptr_q[ev_flow];
        q_ptr  = ptr_q[q_flow];
    end
endmodule

// File: rtl/flow_est_counter.sv
// Module: top of the probabilistic flow counter. Stage 0 latches the
// event and its index (forwarded from stage 1 on a same-flow hit), stage 1
// draws, decides and writes back. Query output is registered.
// Assumes one event per cycle and a table loaded before counting.
module flow_est_counter
    import est_pkg::*;
#(
    parameter int NUM_FLOWS = 64,
    parameter int NUM_EST   = 16,
    parameter int EST_W     = 32,
    parameter int PROB_W    = 16,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
    localparam int FLOW_W   = $clog2(NUM_FLOWS),
    localparam int IDX_W    = $clog2(NUM_EST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FLOW_W-1:0] flow_id,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [EST_W-1:0]  tbl_est,
    input  logic [PROB_W:0]   tbl_prob,
    input  logic [FLOW_W-1:0] rd_flow_id,
    output logic [EST_W-1:0]  rd_estimate
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_EST - 1);

    logic              s1_valid;
    logic [FLOW_W-1:0] s1_flow;
    logic [IDX_W-1:0]  s1_ptr;
    logic [IDX_W-1:0]  s1_next;
    logic [PROB_W:0]   s1_prob;
    logic [IDX_W-1:0]  ev_ptr_raw;
    logic [IDX_W-1:0]  q_ptr;
    logic [EST_W-1:0]  q_est;
    logic [LFSR_W-1:0] rnd;
    logic              draw_hit;
    logic              same_flow;

    est_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    est_table #(.NUM_EST(NUM_EST), .EST_W(EST_W), .PROB_W(PROB_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_est  (tbl_est),
        .wr_prob (tbl_prob),
        .lk_idx  (s1_ptr),
        .lk_prob (s1_prob),
        .q_idx   (q_ptr),
        .q_est   (q_est)
    );

    flow_ptr_ram #(.NUM_FLOWS(NUM_FLOWS), .IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (s1_valid),
        .wr_flow (s1_flow),
        .wr_ptr  (s1_next),
        .ev_flow (flow_id),
        .ev_ptr  (ev_ptr_raw),
        .q_flow  (rd_flow_id),
        .q_ptr   (q_ptr)
    );

    // Draw against the probability and saturate at the last entry.
    always_comb begin
        draw_hit  = ({1'b0, rnd} < s1_prob);
        s1_next   = (draw_hit && s1_ptr != TOP_IDX) ? s1_ptr + 1'b1 : s1_ptr;
        same_flow = s1_valid && (s1_flow == flow_id);
    end

    // Latch the event, forwarding the in-flight update on a same-flow hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_flow  <= '0;
            s1_ptr   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_flow  <= flow_id;
            s1_ptr   <= same_flow ? s1_next : ev_ptr_raw;
        end
    end

    // Register the query result.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_estimate <= '0;
        else        rd_estimate <= q_est;
    end
endmodule

// File: rtl/flow_est_counter_chk.sv
// Checker: timing properties of the update stage and the query port.
module flow_est_counter_chk #(
    parameter int NUM_EST = 16,
    parameter int EST_W   = 32,
    parameter int PROB_W  = 16,
    parameter int FLOW_W  = 6,
    localparam int IDX_W  = $clog2(NUM_EST)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s1_valid,
    input logic [FLOW_W-1:0] s1_flow,
    input logic [IDX_W-1:0]  s1_ptr,
    input logic [IDX_W-1:0]  s1_next,
    input logic [PROB_W:0]   s1_prob,
    input logic [EST_W-1:0]  rd_estimate
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_EST - 1);
    localparam logic [PROB_W:0]  CERTAIN = (PROB_W+1)'(1) << PROB_W;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rd_estimate == '0); // R1
    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_next == s1_ptr || s1_next == s1_ptr + 1'b1)); // R3
    AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_ptr == TOP_IDX) |-> s1_next == TOP_IDX); // R4
    AST_ZERO_PROB: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_prob == '0) |-> s1_next == s1_ptr); // R5
    AST_SURE_PROB: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_prob == CERTAIN && s1_ptr != TOP_IDX) |-> s1_next == s1_ptr + 1'b1); // R5
    AST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && $past(s1_valid) && s1_flow == $past(s1_flow)) |-> s1_ptr == $past(s1_next)); // R6
endmodule

bind flow_est_counter flow_est_counter_chk #(
    .NUM_EST (NUM_EST),
    .EST_W   (EST_W),
    .PROB_W  (PROB_W),
    .FLOW_W  (FLOW_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s1_valid    (s1_valid),
    .s1_flow     (s1_flow),
    .s1_ptr      (s1_ptr),
    .s1_next     (s1_next),
    .s1_prob     (s1_prob),
    .rd_estimate (rd_estimate)
);

// File: tb/flow_est_counter_bench.sv
// Bench: directed corner cases plus seeded random event streams, all with
// probabilities of 0 or certain so a model predicts each index exactly.
module flow_est_counter_bench;
    localparam int NF = 64;
    localparam int NE = 16;
    localparam int EW = 32;
    localparam int PW = 16;
    localparam int FW = $clog2(NF);
    localparam int IW = $clog2(NE);
    localparam logic [PW:0] SURE = (PW+1)'(1) << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [FW-1:0] flow_id = '0;
    logic          tbl_we = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic [EW-1:0] tbl_est = '0;
    logic [PW:0]   tbl_prob = '0;
    logic [FW-1:0] rd_flow_id = '0;
    logic [EW-1:0] rd_estimate;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int seed_dummy;

    logic [EW-1:0] m_est  [NE];
    logic [PW:0]   m_prob [NE];
    int            m_ptr  [NF];

    flow_est_counter #(.NUM_FLOWS(NF), .NUM_EST(NE), .EST_W(EW), .PROB_W(PW)) u_flow_est_counter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .flow_id(flow_id),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_est(tbl_est), .tbl_prob(tbl_prob),
        .rd_flow_id(rd_flow_id), .rd_estimate(rd_estimate)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Bench model of one event for a flow.
    function automatic int model_next(input int p);
        if (m_prob[p] == SURE && p < NE - 1) return p + 1;
        return p;
    endfunction

    function automatic logic [EW-1:0] model_est(input int f);
        return (m_ptr[f] == 0) ? '0 : m_est[m_ptr[f]];
    endfunction

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            tbl_we   = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        for (int f = 0; f < NF; f++) m_ptr[f] = 0;
        for (int e = 0; e < NE; e++) begin
            m_est[e]  = '0;
            m_prob[e] = '0;
        end
    endtask

    task automatic tbl_write(input int idx, input logic [EW-1:0] est, input logic [PW:0] prob);
        @(negedge clk);
        in_valid = 1'b0;
        tbl_we   = 1'b1;
        tbl_idx  = IW'(idx);
        tbl_est  = est;
        tbl_prob = prob;
        m_prob[idx] = prob;
        if (idx != 0) m_est[idx] = est;
    endtask

    task automatic do_event(input int f);
        @(negedge clk);
        tbl_we   = 1'b0;
        in_valid = 1'b1;
        flow_id  = FW'(f);
        m_ptr[f] = model_next(m_ptr[f]);
    endtask

    task automatic query(input int f, input string req);
        @(negedge clk);
        in_valid   = 1'b0;
        tbl_we     = 1'b0;
        rd_flow_id = FW'(f);
        @(negedge clk);
        checks = checks + 1;
        if (rd_estimate !== model_est(f)) begin
            errors = errors + 1;
            $display("FAIL %s flow %0d: actual %0d expected %0d", req, f, rd_estimate, model_est(f));
        end
    endtask

    // Load a table: estimate grows with index; probability certain or zero.
    task automatic load_table(input bit randomize_prob);
        for (int e = 0; e < NE; e++) begin
            logic [PW:0] p;
            p = SURE;
            if (randomize_prob && ($urandom % 5) == 0) p = '0;
            tbl_write(e, EW'(e * e * 256 + e * 64 + 128), p);
        end
    endtask

    initial begin
        seed_dummy = $urandom(32'h5EED_1234);
        do_reset();

        // R1: reset state.
        @(negedge clk);
        checks = checks + 1;
        if (rd_estimate !== '0) begin
            errors = errors + 1;
            $display("FAIL R1 rd_estimate after reset: actual %0d expected 0", rd_estimate);
        end
        query(0, "R1");
        query(NF - 1, "R1");

        // R5: all probabilities zero after reset, so events never advance.
        do_event(2); do_event(2); idle(2);
        query(2, "R5");

        // R2 and R8: load table; entry 0 write ignores its estimate.
        load_table(1'b0);
        tbl_write(0, 32'd1234, SURE);
        idle(1);
        query(7, "R8");

        // R6: back-to-back same-flow events all take effect.
        for (int k = 0; k < 4; k++) do_event(5);
        idle(2);
        query(5, "R6");
        // R9: neighbour flows untouched.
        query(4, "R9");
        query(6, "R9");

        // R2: rewrite the entry flow 5 points at, then query.
        tbl_write(4, 32'd99999, SURE);
        query(5, "R2");

        // R7: one-cycle latency, with event two cycles before query.
        do_event(9);
        idle(1);
        query(9, "R7");

        // R4: saturation under a long burst.
        for (int k = 0; k < 40; k++) do_event(11);
        idle(2);
        query(11, "R4");
        do_event(11); do_event(11); idle(2);
        query(11, "R4");

        // R5: a zero-probability entry blocks progress.
        tbl_write(3, m_est[3], '0);
        for (int k = 0; k < 6; k++) do_event(12);
        idle(2);
        query(12, "R5");

        // Random phase: fresh table with random blocking entries.
        do_reset();
        load_table(1'b1);
        for (int round = 0; round < 3; round++) begin
            for (int n = 0; n < 300; n++) begin
                int gap;
                do_event(int'($urandom % 8));
                gap = int'($urandom % 4);
                if (gap == 3) idle(1);
            end
            idle(2);
            for (int f = 0; f < 8; f++) query(f, "R3");
            query(20, "R9");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule